// File: doc/BRIEF.md
# TCAM Staging-Cache Command Engine

This block sits beside a ternary lookup array and carries out every update to it through one row-sized staging cache. Software fills the cache with key words, mask words, a type-group word, action words and hit-counter words through a plain register port. It then writes a control word naming a command, a row and a start bit. The engine copies the cache into one row, copies one row back into the cache, slides a block of rows by one position in either direction, or fills a run of rows from the cache. The start bit reads back as 1 while the command runs and drops to 0 when it is done.

Each row has three parts that the engine treats separately: the entry part (key, mask and type-group), the action part and the counter part. Three disable bits in the control word keep a command away from any of them. In the mask words a stored 1 marks the key bit as "don't care". The engine copies mask words as they are and never inverts them. Row lookup and matching are not part of this block.

Top module: `tcam_cache_engine`

## Requirements
- R1: After reset every cache word, every row of all three parts, the count register and the control word read as zero.
- R2: Command 0 (write) copies the enabled parts of the cache into the addressed row and takes one row step.
- R3: Command 1 (read) copies the enabled parts of the addressed row into the cache. Cache parts whose disable bit is set keep their contents, and no row changes.
- R4: Control bits 4, 5 and 6 disable the entry, action and counter part. A disabled part of the array is left unchanged by any command.
- R5: After the clock edge that accepts a command, the start bit (control bit 3) reads 1 for n+1 cycles and then 0. Here n is the number of row steps: 1 for read and write, the entry count for moves, and the larger of the enabled counts for initialize.
- R6: The engine ignores a start request whose command code is 5 to 7, or whose entry part is enabled with a row address at or above the row count. The start bit reads 0 in the next cycle and no row or cache word changes.
- R7: Command 2 (move up) takes k from 0 to count-1 in ascending order and copies row base+k into row base+k-1 for the enabled parts. Copies from row 0 or from beyond the last row are skipped, and the row at the top of the block keeps its contents.
- R8: Command 3 (move down) takes k from count-1 down to 0 and copies row base+k into row base+k+1 for the enabled parts. Copies that would land beyond the last row are skipped, and the row at the base of the block keeps its contents.
- R9: Command 4 (initialize) writes the cache entry part into rows base to base+ecount-1. It writes the action and counter parts into rows base to base+acount-1. Rows beyond the last row are skipped.
- R10: While the start bit is set, writes to the cache, the control word and the count register are ignored.
- R11: Register map on an 8-bit address. 0x00 is control: [2:0] command, [3] start, [6:4] disables, [31:16] row. 0x01 is count: [15:0] ecount, [31:16] acount. 0x10+i is entry word i, 0x20+i is mask word i, 0x30+i is action word i, 0x40+i is counter word i, and 0x44 is type-group. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr_i | input | 8 | Register address for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |

## Verification
A wrong row or step counter shows first as a start bit that stays high one cycle too long or too short, visible on the very next read of the control word. Corrupted array contents cannot be seen directly. They appear only after a later read command has pulled the row into the cache, so every scenario ends by reading back each row it could have touched and comparing every cache word against a bench model. An address that wraps instead of being rejected shows up as a changed row that aliases the out-of-range address, found on the same read-back.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam logic [2:0] CMD_WR    = 3'd0;
  localparam logic [2:0] CMD_RD    = 3'd1;
  localparam logic [2:0] CMD_MV_UP = 3'd2;
  localparam logic [2:0] CMD_MV_DN = 3'd3;
  localparam logic [2:0] CMD_INIT  = 3'd4;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CNT  = 8'h01;
  localparam logic [7:0] A_ENT  = 8'h10;
  localparam logic [7:0] A_MSK  = 8'h20;
  localparam logic [7:0] A_ACT  = 8'h30;
  localparam logic [7:0] A_CTR  = 8'h40;
  localparam logic [7:0] A_TG   = 8'h44;

  localparam int START_BIT = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN} tce_state_e;
endpackage

// File: rtl/tce_row_mem.sv
module tce_row_mem #(
  parameter int ROWS = 16,
  parameter int W    = 32,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = (32'(rd_addr_i) < ROWS) ? mem_q[rd_addr_i] : '0;

  AST_MEM_WR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> 32'(wr_addr_i) < ROWS); // R6
endmodule

// File: rtl/tce_cache.sv
module tce_cache
  import tce_pkg::*;
#(
  parameter int ENT_WORDS = 2,
  parameter int ACT_WORDS = 2,
  parameter int CNT_WORDS = 1,
  localparam int EBITS = 64*ENT_WORDS + 32,
  localparam int ABITS = 32*ACT_WORDS,
  localparam int CBITS = 32*CNT_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic             busy_i,
  input  logic [2:0]       load_i,
  input  logic [EBITS-1:0] ent_d_i,
  input  logic [ABITS-1:0] act_d_i,
  input  logic [CBITS-1:0] cnt_d_i,
  output logic [EBITS-1:0] ent_o,
  output logic [ABITS-1:0] act_o,
  output logic [CBITS-1:0] cnt_o,
  output logic [31:0]      rdata_o
);
  // entry part packing: {tg, mask words, key words}
  localparam int MSK_LSB = 32*ENT_WORDS;
  localparam int TG_LSB  = 64*ENT_WORDS;

  logic [EBITS-1:0] ent_q;
  logic [ABITS-1:0] act_q;
  logic [CBITS-1:0] cnt_q;
  logic             wr_ok;

  assign wr_ok = reg_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_i[0]) ent_q <= ent_d_i;
      if (load_i[1]) act_q <= act_d_i;
      if (load_i[2]) cnt_q <= cnt_d_i;
      if (wr_ok) begin
        for (int i = 0; i < ENT_WORDS; i++) begin
          if (reg_addr_i == A_ENT + 8'(i)) ent_q[32*i +: 32] <= reg_wdata_i;
          if (reg_addr_i == A_MSK + 8'(i)) ent_q[MSK_LSB + 32*i +: 32] <= reg_wdata_i;
        end
        if (reg_addr_i == A_TG) ent_q[TG_LSB +: 32] <= reg_wdata_i;
        for (int i = 0; i < ACT_WORDS; i++)
          if (reg_addr_i == A_ACT + 8'(i)) act_q[32*i +: 32] <= reg_wdata_i;
        for (int i = 0; i < CNT_WORDS; i++)
          if (reg_addr_i == A_CTR + 8'(i)) cnt_q[32*i +: 32] <= reg_wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < ENT_WORDS; i++) begin
      if (reg_addr_i == A_ENT + 8'(i)) rdata_o = ent_q[32*i +: 32];
      if (reg_addr_i == A_MSK + 8'(i)) rdata_o = ent_q[MSK_LSB + 32*i +: 32];
    end
    if (reg_addr_i == A_TG) rdata_o = ent_q[TG_LSB +: 32];
    for (int i = 0; i < ACT_WORDS; i++)
      if (reg_addr_i == A_ACT + 8'(i)) rdata_o = act_q[32*i +: 32];
    for (int i = 0; i < CNT_WORDS; i++)
      if (reg_addr_i == A_CTR + 8'(i)) rdata_o = cnt_q[32*i +: 32];
  end

  assign ent_o = ent_q;
  assign act_o = act_q;
  assign cnt_o = cnt_q;

  AST_CACHE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && load_i == 3'b000) |=> ($stable(ent_q) && $stable(act_q) && $stable(cnt_q))); // R10
  AST_LOAD_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i != 3'b000) |-> busy_i); // R3
endmodule

// File: rtl/tce_seq.sv
module tce_seq
  import tce_pkg::*;
#(
  parameter int ROWS = 16,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          cnt_we_i,
  input  logic [31:0]   wdata_i,
  output logic          busy_o,
  output logic [31:0]   ctrl_rd_o,
  output logic [31:0]   cnt_rd_o,
  output logic [2:0]    mem_we_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          use_mem_o,
  output logic [2:0]    cache_load_o
);
  tce_state_e  state_q;
  logic [2:0]  cmd_q, dis_q;
  logic [15:0] base_q, step_q, nrows_q, cnt_e_q, cnt_a_q, nrows_d;
  logic [2:0]  w_cmd, w_dis, en;
  logic [15:0] w_addr;
  logic        bad, ok, step_lt_e, step_lt_a;
  logic [16:0] src, dst, base17, step17;
  logic        unused_ok;

  assign w_cmd  = wdata_i[2:0];
  assign w_dis  = wdata_i[6:4];
  assign w_addr = wdata_i[31:16];
  assign unused_ok = ^wdata_i[15:7];
  assign bad = (w_cmd > CMD_INIT) || (!w_dis[0] && 32'(w_addr) >= ROWS);
  assign busy_o = (state_q != ST_IDLE);
  assign en = ~dis_q;

  always_comb begin
    logic [15:0] ne, na;
    ne = dis_q[0] ? 16'd0 : cnt_e_q;
    na = (&dis_q[2:1]) ? 16'd0 : cnt_a_q;
    case (cmd_q)
      CMD_WR, CMD_RD:       nrows_d = 16'd1;
      CMD_MV_UP, CMD_MV_DN: nrows_d = cnt_e_q;
      default:              nrows_d = (ne > na) ? ne : na;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      dis_q   <= '0;
      base_q  <= '0;
      step_q  <= '0;
      nrows_q <= '0;
      cnt_e_q <= '0;
      cnt_a_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ctrl_we_i) begin
            cmd_q  <= w_cmd;
            dis_q  <= w_dis;
            base_q <= w_addr;
            if (wdata_i[START_BIT] && !bad) state_q <= ST_PREP;
          end
          if (cnt_we_i) {cnt_a_q, cnt_e_q} <= wdata_i;
        end
        ST_PREP: begin
          nrows_q <= nrows_d;
          step_q  <= '0;
          state_q <= (nrows_d == 16'd0) ? ST_IDLE : ST_RUN;
        end
        default: begin
          step_q <= step_q + 16'd1;
          if (step_q + 16'd1 == nrows_q) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign base17    = {1'b0, base_q};
  assign step17    = {1'b0, step_q};
  assign step_lt_e = step_q < cnt_e_q;
  assign step_lt_a = step_q < cnt_a_q;

  // one row step per RUN cycle
  always_comb begin
    src = '0;
    dst = '0;
    ok = 1'b0;
    mem_we_o = '0;
    cache_load_o = '0;
    use_mem_o = 1'b0;
    if (state_q == ST_RUN) begin
      case (cmd_q)
        CMD_WR: begin
          dst = base17;
          ok = 32'(dst) < ROWS;
          mem_we_o = en & {3{ok}};
        end
        CMD_RD: begin
          src = base17;
          ok = 32'(src) < ROWS;
          cache_load_o = en & {3{ok}};
        end
        CMD_MV_UP: begin
          src = base17 + step17;
          dst = src - 17'd1;
          ok = (32'(src) < ROWS) && (src != 17'd0);
          mem_we_o = en & {3{ok}};
          use_mem_o = 1'b1;
        end
        CMD_MV_DN: begin
          src = base17 + {1'b0, nrows_q} - 17'd1 - step17;
          dst = src + 17'd1;
          ok = 32'(dst) < ROWS;
          mem_we_o = en & {3{ok}};
          use_mem_o = 1'b1;
        end
        default: begin
          dst = base17 + step17;
          ok = 32'(dst) < ROWS;
          mem_we_o = {en[2] & step_lt_a, en[1] & step_lt_a, en[0] & step_lt_e} & {3{ok}};
        end
      endcase
    end
  end

  assign wr_addr_o = dst[AW-1:0];
  assign rd_addr_o = src[AW-1:0];
  assign ctrl_rd_o = {base_q, 9'd0, dis_q, busy_o, cmd_q};
  assign cnt_rd_o  = {cnt_a_q, cnt_e_q};

  AST_REJECT_BAD_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREP) |-> (dis_q[0] || 32'(base_q) < ROWS)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> (mem_we_o == 3'b000 && cache_load_o == 3'b000)); // R5
  AST_READ_NO_ARRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD) |-> (mem_we_o == 3'b000)); // R3
  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (step_q < nrows_q)); // R5
  AST_DISABLED_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_we_o | cache_load_o) & dis_q) == 3'b000); // R4
endmodule

// File: rtl/tcam_cache_engine.sv
module tcam_cache_engine
  import tce_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int ENT_WORDS = 2,
  parameter int ACT_WORDS = 2,
  parameter int CNT_WORDS = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  localparam int AW    = $clog2(ROWS);
  localparam int EBITS = 64*ENT_WORDS + 32;
  localparam int ABITS = 32*ACT_WORDS;
  localparam int CBITS = 32*CNT_WORDS;

  logic             busy, use_mem;
  logic [2:0]       mem_we, cache_load;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [31:0]      ctrl_rd, cnt_rd, cache_rd;
  logic [EBITS-1:0] ent_c, ent_m;
  logic [ABITS-1:0] act_c, act_m;
  logic [CBITS-1:0] cnt_c, cnt_m;

  tce_seq #(.ROWS(ROWS)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctrl_we_i(reg_we_i && reg_addr_i == A_CTRL),
    .cnt_we_i(reg_we_i && reg_addr_i == A_CNT),
    .wdata_i(reg_wdata_i),
    .busy_o(busy), .ctrl_rd_o(ctrl_rd), .cnt_rd_o(cnt_rd),
    .mem_we_o(mem_we), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .use_mem_o(use_mem), .cache_load_o(cache_load)
  );

  tce_cache #(.ENT_WORDS(ENT_WORDS), .ACT_WORDS(ACT_WORDS), .CNT_WORDS(CNT_WORDS)) i_cache (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .busy_i(busy), .load_i(cache_load),
    .ent_d_i(ent_m), .act_d_i(act_m), .cnt_d_i(cnt_m),
    .ent_o(ent_c), .act_o(act_c), .cnt_o(cnt_c), .rdata_o(cache_rd)
  );

  tce_row_mem #(.ROWS(ROWS), .W(EBITS)) i_ent_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we[0]), .wr_addr_i(wr_addr),
    .wr_data_i(use_mem ? ent_m : ent_c), .rd_addr_i(rd_addr), .rd_data_o(ent_m)
  );

  tce_row_mem #(.ROWS(ROWS), .W(ABITS)) i_act_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we[1]), .wr_addr_i(wr_addr),
    .wr_data_i(use_mem ? act_m : act_c), .rd_addr_i(rd_addr), .rd_data_o(act_m)
  );

  tce_row_mem #(.ROWS(ROWS), .W(CBITS)) i_cnt_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we[2]), .wr_addr_i(wr_addr),
    .wr_data_i(use_mem ? cnt_m : cnt_c), .rd_addr_i(rd_addr), .rd_data_o(cnt_m)
  );

  always_comb begin
    if (reg_addr_i == A_CTRL)     reg_rdata_o = ctrl_rd;
    else if (reg_addr_i == A_CNT) reg_rdata_o = cnt_rd;
    else                          reg_rdata_o = cache_rd;
  end
endmodule

// File: tb/test_tcam_cache_engine.sv
`timescale 1ns/1ps
module test_tcam_cache_engine;
  localparam int ROWS = 16;
  localparam int EW = 2;
  localparam int AWD = 2;
  localparam int CW = 1;
  localparam int NE = 2*EW + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cnt_e = 0;
  int cnt_a = 0;

  logic [31:0] m_ent [ROWS][NE];
  logic [31:0] m_act [ROWS][AWD];
  logic [31:0] m_cnt [ROWS][CW];
  logic [31:0] c_ent [NE];
  logic [31:0] c_act [AWD];
  logic [31:0] c_cnt [CW];

  always #4 clk = ~clk;

  tcam_cache_engine #(.ROWS(ROWS), .ENT_WORDS(EW), .ACT_WORDS(AWD), .CNT_WORDS(CW)) i_tcam_cache_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  function automatic logic [7:0] ent_addr(int i);
    if (i < EW) return 8'h10 + 8'(i);
    if (i < 2*EW) return 8'h20 + 8'(i - EW);
    return 8'h44;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] d;
    cyc = 0;
    reg_rd(8'h00, d);
    while (d[3] && cyc < 1000) begin
      cyc++;
      @(negedge clk);
      reg_rd(8'h00, d);
    end
  endtask

  task automatic run_cmd(logic [2:0] cmd, logic [2:0] dis, logic [15:0] row, output int cyc);
    reg_wr(8'h00, {row, 9'd0, dis, 1'b1, cmd});
    wait_idle(cyc);
  endtask

  task automatic set_counts(int e, int a);
    cnt_e = e; cnt_a = a;
    reg_wr(8'h01, {16'(a), 16'(e)});
  endtask

  task automatic load_cache(int seed);
    for (int i = 0; i < NE; i++) begin
      c_ent[i] = 32'(seed) * 32'h01000193 + 32'(i);
      reg_wr(ent_addr(i), c_ent[i]);
    end
    for (int i = 0; i < AWD; i++) begin
      c_act[i] = 32'(seed) * 32'h00010003 + 32'h100 + 32'(i);
      reg_wr(8'h30 + 8'(i), c_act[i]);
    end
    for (int i = 0; i < CW; i++) begin
      c_cnt[i] = 32'(seed) * 32'h00000101 + 32'h7000 + 32'(i);
      reg_wr(8'h40 + 8'(i), c_cnt[i]);
    end
  endtask

  task automatic verify_cache(string req);
    logic [31:0] d;
    for (int i = 0; i < NE; i++) begin reg_rd(ent_addr(i), d); chk(req, d, c_ent[i]); end
    for (int i = 0; i < AWD; i++) begin reg_rd(8'h30 + 8'(i), d); chk(req, d, c_act[i]); end
    for (int i = 0; i < CW; i++) begin reg_rd(8'h40 + 8'(i), d); chk(req, d, c_cnt[i]); end
  endtask

  task automatic copy_row(int s, int t, logic [2:0] dis);
    if (!dis[0]) for (int i = 0; i < NE; i++) m_ent[t][i] = m_ent[s][i];
    if (!dis[1]) for (int i = 0; i < AWD; i++) m_act[t][i] = m_act[s][i];
    if (!dis[2]) for (int i = 0; i < CW; i++) m_cnt[t][i] = m_cnt[s][i];
  endtask

  task automatic cache_to_row(int t, logic [2:0] dis, bit ent_ok, bit ac_ok);
    if (!dis[0] && ent_ok) for (int i = 0; i < NE; i++) m_ent[t][i] = c_ent[i];
    if (!dis[1] && ac_ok) for (int i = 0; i < AWD; i++) m_act[t][i] = c_act[i];
    if (!dis[2] && ac_ok) for (int i = 0; i < CW; i++) m_cnt[t][i] = c_cnt[i];
  endtask

  // model of R2, R3, R7, R8, R9
  task automatic model_cmd(logic [2:0] cmd, logic [2:0] dis, int base);
    case (cmd)
      3'd0: if (base < ROWS) cache_to_row(base, dis, 1'b1, 1'b1);
      3'd1: if (base < ROWS) begin
        if (!dis[0]) for (int i = 0; i < NE; i++) c_ent[i] = m_ent[base][i];
        if (!dis[1]) for (int i = 0; i < AWD; i++) c_act[i] = m_act[base][i];
        if (!dis[2]) for (int i = 0; i < CW; i++) c_cnt[i] = m_cnt[base][i];
      end
      3'd2: for (int k = 0; k < cnt_e; k++) begin
        if (base + k < ROWS && base + k >= 1) copy_row(base + k, base + k - 1, dis);
      end
      3'd3: for (int k = cnt_e - 1; k >= 0; k--) begin
        if (base + k + 1 < ROWS) copy_row(base + k, base + k + 1, dis);
      end
      3'd4: for (int k = 0; k < 65536; k++) begin
        if (k >= cnt_e && k >= cnt_a) break;
        if (base + k < ROWS) cache_to_row(base + k, dis, k < cnt_e, k < cnt_a);
      end
      default: ;
    endcase
  endtask

  task automatic check_row(int r, string req);
    int cyc;
    run_cmd(3'd1, 3'b000, 16'(r), cyc);
    model_cmd(3'd1, 3'b000, r);
    verify_cache(req);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    reg_rd(8'h01, d); chk("R1 count", d, 32'h0);
    reg_rd(8'h55, d); chk("R11 unmapped", d, 32'h0);
    verify_cache("R1 cache");
    check_row(5, "R1 row5");
    check_row(15, "R1 row15");
  endtask

  task automatic t_write_read();
    int cyc;
    load_cache(1);
    run_cmd(3'd0, 3'b000, 16'd3, cyc); model_cmd(3'd0, 3'b000, 3);
    chk("R5 write cycles", 32'(cyc), 32'd2);
    load_cache(2);
    run_cmd(3'd1, 3'b000, 16'd3, cyc); model_cmd(3'd1, 3'b000, 3);
    chk("R5 read cycles", 32'(cyc), 32'd2);
    verify_cache("R2 R3 write then read");
  endtask

  task automatic t_disable();
    int cyc;
    load_cache(3);
    run_cmd(3'd0, 3'b000, 16'd4, cyc); model_cmd(3'd0, 3'b000, 4);
    load_cache(4);
    run_cmd(3'd0, 3'b010, 16'd4, cyc); model_cmd(3'd0, 3'b010, 4);
    load_cache(8);
    run_cmd(3'd0, 3'b101, 16'd5, cyc); model_cmd(3'd0, 3'b101, 5);
    check_row(4, "R4 action kept");
    check_row(5, "R4 only action");
    load_cache(5);
    run_cmd(3'd1, 3'b100, 16'd4, cyc); model_cmd(3'd1, 3'b100, 4);
    verify_cache("R3 counter cache kept");
  endtask

  task automatic t_reject();
    int cyc;
    load_cache(6);
    run_cmd(3'd0, 3'b000, 16'd20, cyc);
    chk("R6 bad row start", 32'(cyc), 32'd0);
    run_cmd(3'd5, 3'b000, 16'd2, cyc);
    chk("R6 bad code start", 32'(cyc), 32'd0);
    run_cmd(3'd7, 3'b000, 16'd4, cyc);
    chk("R6 code 7 start", 32'(cyc), 32'd0);
    verify_cache("R6 cache kept");
    check_row(4, "R6 alias row");
    check_row(2, "R6 row2");
  endtask

  task automatic t_move_up();
    int cyc;
    for (int r = 6; r <= 9; r++) begin
      load_cache(10 + r);
      run_cmd(3'd0, 3'b000, 16'(r), cyc); model_cmd(3'd0, 3'b000, r);
    end
    set_counts(3, 0);
    run_cmd(3'd2, 3'b000, 16'd7, cyc); model_cmd(3'd2, 3'b000, 7);
    chk("R5 move cycles", 32'(cyc), 32'd4);
    for (int r = 6; r <= 9; r++) check_row(r, "R7 move up");
  endtask

  task automatic t_move_down();
    int cyc;
    for (int r = 10; r <= 13; r++) begin
      load_cache(20 + r);
      run_cmd(3'd0, 3'b000, 16'(r), cyc); model_cmd(3'd0, 3'b000, r);
    end
    set_counts(3, 0);
    run_cmd(3'd3, 3'b000, 16'd10, cyc); model_cmd(3'd3, 3'b000, 10);
    for (int r = 10; r <= 13; r++) check_row(r, "R8 move down");
    set_counts(2, 0);
    run_cmd(3'd3, 3'b000, 16'd14, cyc); model_cmd(3'd3, 3'b000, 14);
    check_row(15, "R8 edge skip");
  endtask

  task automatic t_init();
    int cyc;
    load_cache(30);
    set_counts(3, 5);
    run_cmd(3'd4, 3'b000, 16'd11, cyc); model_cmd(3'd4, 3'b000, 11);
    chk("R5 init cycles", 32'(cyc), 32'd6);
    for (int r = 10; r <= 15; r++) check_row(r, "R9 init");
    load_cache(31);
    set_counts(7, 2);
    run_cmd(3'd4, 3'b001, 16'd0, cyc); model_cmd(3'd4, 3'b001, 0);
    chk("R5 init no entry cycles", 32'(cyc), 32'd3);
    for (int r = 0; r <= 2; r++) check_row(r, "R9 init action only");
  endtask

  task automatic t_busy_block();
    int cyc;
    logic [31:0] d;
    load_cache(40);
    set_counts(8, 1);
    reg_wr(8'h00, {16'd1, 9'd0, 3'b000, 1'b1, 3'd2});
    reg_wr(8'h10, 32'hdead_beef);
    reg_wr(8'h01, 32'h0003_0004);
    reg_wr(8'h00, {16'd2, 9'd0, 3'b000, 1'b1, 3'd0});
    wait_idle(cyc);
    model_cmd(3'd2, 3'b000, 1);
    verify_cache("R10 cache kept");
    reg_rd(8'h01, d); chk("R10 count kept", d, 32'h0001_0008);
    reg_rd(8'h00, d); chk("R10 ctrl kept", d[31:16], 32'd1);
    for (int r = 0; r <= 9; r++) check_row(r, "R10 R7 rows");
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i < NE; i++) m_ent[r][i] = '0;
      for (int i = 0; i < AWD; i++) m_act[r][i] = '0;
      for (int i = 0; i < CW; i++) m_cnt[r][i] = '0;
    end
    for (int i = 0; i < NE; i++) c_ent[i] = '0;
    for (int i = 0; i < AWD; i++) c_act[i] = '0;
    for (int i = 0; i < CW; i++) c_cnt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_disable();
    t_reject();
    t_move_up();
    t_move_down();
    t_init();
    t_busy_block();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule